// File: doc/BRIEF.md
# Crypto Engine Command Queue Decoder

This block sits between a processor's register write port and a cipher datapath. Software pushes 32-bit command words into a short inbound queue. A sequencer pulls the words out in order, decodes the six-bit opcode in the top bits and drives one of three back-end units: the block cipher engine, a mover that copies words between external memory and internal RAM, and the key-table loader. Each unit is reached through a one-cycle start pulse, a set of field outputs and a done input. Two opcodes take the next queued word as a 32-bit address operand. When that word has not arrived yet, the sequencer waits for it.

Status outputs show whether the sequencer is busy, whether the queue is empty and whether the memory mover is running. Four interrupt sources are gathered into a status register:

- end of a cipher operation
- unknown opcode
- queue overflow
- end of a memory move

Software clears the status bits by writing one to them, and sets a separate enable register. The interrupt line is high whenever an enabled status bit is set.

Top module: `cmdq_decoder`

## Requirements
- R1: After a synchronous reset the queue is empty, the busy and mover-busy flags are low, the interrupt status is zero, the interrupt line is low and every start pulse is low.
- R2: The queue holds at most 5 words and hands them out in the order they were written. A write while it holds 5 words is dropped and sets interrupt status bit 2.
- R3: The opcode is bits [31:26]. Opcode 0x10 (source setup) consumes the next queued word and presents it on `eng_src_addr`.
- R4: Opcode 0x0E (engine start) drives `eng_start` high for exactly one cycle and presents bits [11:0] (block count minus one) on `eng_blocks`. The busy flag then stays high until `eng_done`, after which interrupt status bit 0 is set.
- R5: Opcode 0x22 (memory move) takes its direction from bit 25 (0 means external to internal, 1 means internal to external) and its word count from bits [19:12]. The next queued word is the external address. The command pulses `mdma_start` once. `st_dma_busy` stays high until `mdma_done`, after which interrupt status bit 3 is set.
- R6: Opcode 0x15 (key-table load) presents bits [25:24] as the table select, bit 23 as the RAM select and bits [22:17] as the key id, and pulses `key_ld_start` once. The busy flag stays high until `key_ld_done`. At most one start pulse is high in any cycle.
- R7: Opcode 0x11 (transfer close) produces a one-cycle pulse on `xfer_close` and nothing else.
- R8: Any other opcode sets interrupt status bit 1. The word is discarded and the next queued command is decoded normally.
- R9: Writing interrupt-clear data clears each status bit written as one and leaves bits written as zero unchanged.
- R10: `irq` is high exactly when some status bit is set and its enable bit is set.
- R11: When an address-taking opcode is decoded and the queue is empty, the sequencer stays busy and waits until the operand word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| int_clr_we | input | 1 | Interrupt status clear strobe |
| int_clr_data | input | 4 | Bits to clear (write one to clear) |
| int_en_we | input | 1 | Interrupt enable write strobe |
| int_en_data | input | 4 | New interrupt enable value |
| int_status | output | 4 | Interrupt status: 0 op done, 1 bad opcode, 2 overflow, 3 move done |
| irq | output | 1 | Interrupt line |
| st_engine_busy | output | 1 | Sequencer is decoding or waiting for a unit or operand |
| st_queue_empty | output | 1 | Inbound queue holds no word |
| st_dma_busy | output | 1 | Memory mover is running |
| eng_start | output | 1 | Cipher engine start pulse |
| eng_src_addr | output | 32 | Source address from the last setup command |
| eng_blocks | output | 12 | Block count minus one |
| eng_done | input | 1 | Cipher engine finished |
| xfer_close | output | 1 | Transfer close pulse |
| mdma_start | output | 1 | Memory mover start pulse |
| mdma_dir | output | 1 | Mover direction |
| mdma_addr | output | 32 | Mover external address |
| mdma_words | output | 8 | Mover word count |
| mdma_done | input | 1 | Memory mover finished |
| key_ld_start | output | 1 | Key-table load start pulse |
| key_tbl_sel | output | 2 | Table select |
| key_ram_sel | output | 1 | RAM select |
| key_id | output | 6 | Key table id |
| key_ld_done | input | 1 | Key-table load finished |

## Verification
The bench fills the queue while the engine is held busy, then writes one more word. A design that accepted the extra word or lost the order would produce a sixth start pulse or block counts out of sequence. It also issues a setup command with its address word written much later. A decoder that did not wait would latch a stale or empty address, or treat the late address as an opcode. Unknown opcodes are placed directly ahead of valid commands. A decoder that stalled on them, or consumed the following word with them, would miss the next pulse. Random mixes of engine starts, key loads and bad opcodes check the field extraction bit by bit against values the bench computes.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

    typedef enum logic [5:0] {
        OP_ENG_START  = 6'h0E,
        OP_SRC_SETUP  = 6'h10,
        OP_XFER_CLOSE = 6'h11,
        OP_KEY_LOAD   = 6'h15,
        OP_MEM_MOVE   = 6'h22
    } opcode_e;

    localparam int OPC_LSB      = 26;
    localparam int MOVE_DIR_BIT = 25;
    localparam int MOVE_CNT_LSB = 12;
    localparam int TBL_LSB      = 24;
    localparam int RAMSEL_BIT   = 23;
    localparam int KID_LSB      = 17;
    localparam int KID_W        = 6;

    localparam int IRQ_OP_DONE   = 0;
    localparam int IRQ_BAD_OP    = 1;
    localparam int IRQ_OVERFLOW  = 2;
    localparam int IRQ_MOVE_DONE = 3;
    localparam int IRQ_N         = 4;

    typedef enum logic [2:0] {
        S_FETCH,
        S_SRC_ADDR,
        S_MOVE_ADDR,
        S_ENG_RUN,
        S_MOVE_RUN,
        S_KEY_RUN
    } seq_state_e;

    typedef struct packed {
        logic [1:0]       tbl;
        logic             ram;
        logic [KID_W-1:0] id;
    } key_fields_t;

    function automatic logic [5:0] opcode_of(input logic [31:0] w);
        return w[OPC_LSB +: 6];
    endfunction

    function automatic key_fields_t key_fields_of(input logic [31:0] w);
        key_fields_t k;
        k.tbl = w[TBL_LSB +: 2];
        k.ram = w[RAMSEL_BIT];
        k.id  = w[KID_LSB +: KID_W];
        return k;
    endfunction

endpackage

// File: rtl/cqd_fifo.sv
module cqd_fifo #(
    parameter int DEPTH = 5,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overflow_ev
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             full, push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full        = (count == CNT_W'(DEPTH));
    assign empty       = (count == '0);
    assign push        = wr_en && !full;
    assign do_pop      = pop && !empty;
    assign overflow_ev = wr_en && full;
    assign head        = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pop) |=> (count == $past(count))) else $error("dropped write changed fill"); // R2

endmodule

// File: rtl/cqd_irq.sv
module cqd_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    input  logic         en_we,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] en;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            en     <= '0;
        end else begin
            if (en_we) en <= en_data;
            status <= (status & ~(clr_we ? clr_data : '0)) | set_ev;
        end
    end

    assign irq = |(status & en);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_data[0] && !set_ev[0]) |=> !status[0]) else $error("w1c failed"); // R9
    AST_BAD_OP_SETS: assert property (@(posedge clk) disable iff (rst)
        set_ev[1] |=> status[1]) else $error("bad opcode not flagged"); // R8

endmodule

// File: rtl/cqd_sequencer.sv
module cqd_sequencer
    import cqd_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int WCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       head,
    input  logic              empty,
    output logic              pop,
    input  logic              eng_done,
    input  logic              mdma_done,
    input  logic              key_ld_done,
    output logic              eng_start,
    output logic [31:0]       eng_src_addr,
    output logic [BLK_W-1:0]  eng_blocks,
    output logic              xfer_close,
    output logic              mdma_start,
    output logic              mdma_dir,
    output logic [31:0]       mdma_addr,
    output logic [WCNT_W-1:0] mdma_words,
    output logic              key_ld_start,
    output key_fields_t       key_f,
    output logic              ev_done,
    output logic              ev_bad,
    output logic              ev_move,
    output logic              busy,
    output logic              dma_busy
);
    seq_state_e state;
    logic       want;

    assign want     = (state == S_FETCH) || (state == S_SRC_ADDR) || (state == S_MOVE_ADDR);
    assign pop      = want && !empty;
    assign busy     = (state != S_FETCH);
    assign dma_busy = (state == S_MOVE_RUN);
    assign ev_done  = (state == S_ENG_RUN)  && eng_done;
    assign ev_move  = (state == S_MOVE_RUN) && mdma_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_FETCH;
            eng_start    <= 1'b0;
            eng_src_addr <= '0;
            eng_blocks   <= '0;
            xfer_close   <= 1'b0;
            mdma_start   <= 1'b0;
            mdma_dir     <= 1'b0;
            mdma_addr    <= '0;
            mdma_words   <= '0;
            key_ld_start <= 1'b0;
            key_f        <= '0;
            ev_bad       <= 1'b0;
        end else begin
            eng_start    <= 1'b0;
            xfer_close   <= 1'b0;
            mdma_start   <= 1'b0;
            key_ld_start <= 1'b0;
            ev_bad       <= 1'b0;
            case (state)
                S_FETCH: if (!empty) begin
                    case (opcode_of(head))
                        OP_SRC_SETUP: state <= S_SRC_ADDR;
                        OP_ENG_START: begin
                            eng_blocks <= head[BLK_W-1:0];
                            eng_start  <= 1'b1;
                            state      <= S_ENG_RUN;
                        end
                        OP_XFER_CLOSE: xfer_close <= 1'b1;
                        OP_MEM_MOVE: begin
                            mdma_dir   <= head[MOVE_DIR_BIT];
                            mdma_words <= head[MOVE_CNT_LSB +: WCNT_W];
                            state      <= S_MOVE_ADDR;
                        end
                        OP_KEY_LOAD: begin
                            key_f        <= key_fields_of(head);
                            key_ld_start <= 1'b1;
                            state        <= S_KEY_RUN;
                        end
                        default: ev_bad <= 1'b1;
                    endcase
                end
                S_SRC_ADDR: if (!empty) begin
                    eng_src_addr <= head;
                    state        <= S_FETCH;
                end
                S_MOVE_ADDR: if (!empty) begin
                    mdma_addr  <= head;
                    mdma_start <= 1'b1;
                    state      <= S_MOVE_RUN;
                end
                S_ENG_RUN:  if (eng_done)    state <= S_FETCH;
                S_MOVE_RUN: if (mdma_done)   state <= S_FETCH;
                S_KEY_RUN:  if (key_ld_done) state <= S_FETCH;
                default:    state <= S_FETCH;
            endcase
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start) else $error("start pulse too long"); // R4
    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, mdma_start, key_ld_start})) else $error("two launches"); // R6
    AST_MOVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mdma_start |-> dma_busy) else $error("mover not busy at launch"); // R5
    AST_CLOSE_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_close |-> !busy) else $error("close while busy"); // R7

endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
    import cqd_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int BLK_W  = 12,
    parameter int WCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [31:0]       cmd_wdata,
    input  logic              int_clr_we,
    input  logic [3:0]        int_clr_data,
    input  logic              int_en_we,
    input  logic [3:0]        int_en_data,
    output logic [3:0]        int_status,
    output logic              irq,
    output logic              st_engine_busy,
    output logic              st_queue_empty,
    output logic              st_dma_busy,
    output logic              eng_start,
    output logic [31:0]       eng_src_addr,
    output logic [BLK_W-1:0]  eng_blocks,
    input  logic              eng_done,
    output logic              xfer_close,
    output logic              mdma_start,
    output logic              mdma_dir,
    output logic [31:0]       mdma_addr,
    output logic [WCNT_W-1:0] mdma_words,
    input  logic              mdma_done,
    output logic              key_ld_start,
    output logic [1:0]        key_tbl_sel,
    output logic              key_ram_sel,
    output logic [5:0]        key_id,
    input  logic              key_ld_done
);
    logic [31:0]      head;
    logic             empty, pop, ov_ev, ev_done, ev_bad, ev_move;
    logic [IRQ_N-1:0] set_ev;
    key_fields_t      key_f;

    cqd_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(cmd_we), .wr_data(cmd_wdata),
        .pop(pop), .head(head), .empty(empty), .overflow_ev(ov_ev)
    );

    cqd_sequencer #(.BLK_W(BLK_W), .WCNT_W(WCNT_W)) u_seq (
        .clk(clk), .rst(rst), .head(head), .empty(empty), .pop(pop),
        .eng_done(eng_done), .mdma_done(mdma_done), .key_ld_done(key_ld_done),
        .eng_start(eng_start), .eng_src_addr(eng_src_addr), .eng_blocks(eng_blocks),
        .xfer_close(xfer_close), .mdma_start(mdma_start), .mdma_dir(mdma_dir),
        .mdma_addr(mdma_addr), .mdma_words(mdma_words), .key_ld_start(key_ld_start),
        .key_f(key_f), .ev_done(ev_done), .ev_bad(ev_bad), .ev_move(ev_move),
        .busy(st_engine_busy), .dma_busy(st_dma_busy)
    );

    always_comb begin
        set_ev                = '0;
        set_ev[IRQ_OP_DONE]   = ev_done;
        set_ev[IRQ_BAD_OP]    = ev_bad;
        set_ev[IRQ_OVERFLOW]  = ov_ev;
        set_ev[IRQ_MOVE_DONE] = ev_move;
    end

    cqd_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst(rst), .set_ev(set_ev),
        .clr_we(int_clr_we), .clr_data(int_clr_data),
        .en_we(int_en_we), .en_data(int_en_data),
        .status(int_status), .irq(irq)
    );

    assign st_queue_empty = empty;
    assign key_tbl_sel    = key_f.tbl;
    assign key_ram_sel    = key_f.ram;
    assign key_id         = key_f.id;

    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !st_queue_empty && ov_ev) |=> int_status[IRQ_OVERFLOW]) else $error("overflow not flagged"); // R2

endmodule

// File: tb/test_cmdq_decoder.sv
module test_cmdq_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        int_clr_we = 1'b0;
    logic [3:0]  int_clr_data = '0;
    logic        int_en_we = 1'b0;
    logic [3:0]  int_en_data = '0;
    logic [3:0]  int_status;
    logic        irq, st_engine_busy, st_queue_empty, st_dma_busy;
    logic        eng_start, xfer_close, mdma_start, mdma_dir, key_ld_start, key_ram_sel;
    logic [31:0] eng_src_addr, mdma_addr;
    logic [11:0] eng_blocks;
    logic [7:0]  mdma_words;
    logic [1:0]  key_tbl_sel;
    logic [5:0]  key_id;
    logic        eng_done = 1'b0, mdma_done = 1'b0, key_ld_done = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmdq_decoder i_cmdq_decoder (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .int_clr_we(int_clr_we), .int_clr_data(int_clr_data),
        .int_en_we(int_en_we), .int_en_data(int_en_data),
        .int_status(int_status), .irq(irq),
        .st_engine_busy(st_engine_busy), .st_queue_empty(st_queue_empty), .st_dma_busy(st_dma_busy),
        .eng_start(eng_start), .eng_src_addr(eng_src_addr), .eng_blocks(eng_blocks), .eng_done(eng_done),
        .xfer_close(xfer_close), .mdma_start(mdma_start), .mdma_dir(mdma_dir),
        .mdma_addr(mdma_addr), .mdma_words(mdma_words), .mdma_done(mdma_done),
        .key_ld_start(key_ld_start), .key_tbl_sel(key_tbl_sel), .key_ram_sel(key_ram_sel),
        .key_id(key_id), .key_ld_done(key_ld_done)
    );

    function automatic logic [31:0] mk_start(input logic [11:0] n);
        return {6'h0E, 14'd0, n};
    endfunction
    function automatic logic [31:0] mk_key(input logic [2:0] slot);
        return {6'h15, 2'd3, 1'b1, 3'b001, slot, 17'd0};
    endfunction
    function automatic logic [31:0] mk_move(input logic dir, input logic [7:0] n);
        return {6'h22, dir, 5'd0, n, 12'd0};
    endfunction
    function automatic bit known_op(input logic [5:0] op);
        return op == 6'h0E || op == 6'h10 || op == 6'h11 || op == 6'h15 || op == 6'h22;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [31:0] w);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_we = 1'b0;
    endtask
    task automatic clr_int(input logic [3:0] m);
        @(negedge clk); int_clr_we = 1'b1; int_clr_data = m;
        @(negedge clk); int_clr_we = 1'b0;
    endtask
    task automatic set_en(input logic [3:0] m);
        @(negedge clk); int_en_we = 1'b1; int_en_data = m;
        @(negedge clk); int_en_we = 1'b0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit pulse_sig(input int which);
        case (which)
            0: return eng_start;
            1: return mdma_start;
            2: return key_ld_start;
            default: return xfer_close;
        endcase
    endfunction

    // waits at negedges for a pulse; returns with the pulse visible
    task automatic wait_pulse(input int which, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pulse_sig(which)) begin seen = 1'b1; break; end
        end
    endtask
    task automatic pulse_width(input int which, input string req);
        @(negedge clk);
        chk(!pulse_sig(which), req, 32'(pulse_sig(which)), 0);
    endtask

    task automatic done_pulse(input int which);
        @(negedge clk);
        if (which == 0) eng_done = 1'b1; else if (which == 1) mdma_done = 1'b1; else key_ld_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; mdma_done = 1'b0; key_ld_done = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd4711));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(st_queue_empty == 1'b1, "R1 queue empty", 32'(st_queue_empty), 1);
        chk(st_engine_busy == 1'b0 && st_dma_busy == 1'b0, "R1 busy low", {st_engine_busy, st_dma_busy}, 0);
        chk(int_status == 4'd0 && irq == 1'b0, "R1 irq clear", {irq, int_status}, 0);
        chk({eng_start, mdma_start, key_ld_start, xfer_close} == 4'd0, "R1 pulses low",
            {eng_start, mdma_start, key_ld_start, xfer_close}, 0);

        // R3 setup with address word
        wr_cmd({6'h10, 26'd0});
        wr_cmd(32'hA5A5_1234);
        idle(4);
        chk(eng_src_addr == 32'hA5A5_1234, "R3 source address", eng_src_addr, 32'hA5A5_1234);

        // R11 operand arrives late
        wr_cmd({6'h10, 26'd0});
        idle(6);
        chk(st_engine_busy == 1'b1 && st_queue_empty == 1'b1, "R11 waiting for operand",
            {st_engine_busy, st_queue_empty}, 2'b11);
        wr_cmd(32'h0000_BEEF);
        idle(3);
        chk(eng_src_addr == 32'h0000_BEEF && !st_engine_busy, "R11 operand taken", eng_src_addr, 32'h0000_BEEF);

        // R4 engine start
        wr_cmd(mk_start(12'h123));
        wait_pulse(0, seen);
        chk(seen, "R4 start pulse", 32'(seen), 1);
        chk(eng_blocks == 12'h123, "R4 block count", eng_blocks, 12'h123);
        pulse_width(0, "R4 pulse width");
        idle(3);
        chk(st_engine_busy == 1'b1, "R4 busy until done", 32'(st_engine_busy), 1);
        done_pulse(0);
        chk(!st_engine_busy && int_status[0], "R4 done flag", {st_engine_busy, int_status}, 5'b00001);

        // R9 write one to clear
        clr_int(4'b0000);
        chk(int_status[0] == 1'b1, "R9 zero write keeps bit", int_status, 4'b0001);
        clr_int(4'b0001);
        chk(int_status == 4'd0, "R9 one write clears", int_status, 0);

        // R10 + R8 + R7 bad opcode then close
        set_en(4'b0010);
        wr_cmd({6'h3F, 26'h155});
        wr_cmd({6'h11, 26'd0});
        wait_pulse(3, seen);
        chk(seen, "R7 close pulse after bad opcode (R8)", 32'(seen), 1);
        pulse_width(3, "R7 close width");
        chk(int_status[1] == 1'b1, "R8 bad opcode flag", int_status, 4'b0010);
        chk(irq == 1'b1, "R10 irq enabled bit", 32'(irq), 1);
        set_en(4'b0001);
        chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);
        clr_int(4'b1111);

        // R5 memory move
        wr_cmd(mk_move(1'b1, 8'd16));
        wr_cmd(32'h8000_0040);
        wait_pulse(1, seen);
        chk(seen, "R5 move pulse", 32'(seen), 1);
        chk(mdma_dir == 1'b1 && mdma_words == 8'd16, "R5 dir/count", {mdma_dir, mdma_words}, {1'b1, 8'd16});
        chk(mdma_addr == 32'h8000_0040, "R5 address", mdma_addr, 32'h8000_0040);
        idle(2);
        chk(st_dma_busy == 1'b1, "R5 dma busy", 32'(st_dma_busy), 1);
        done_pulse(1);
        chk(!st_dma_busy && int_status[3], "R5 move done", {st_dma_busy, int_status}, 5'b01000);
        wr_cmd(mk_move(1'b0, 8'd3));
        wr_cmd(32'h1234_0000);
        wait_pulse(1, seen);
        chk(seen && mdma_dir == 1'b0 && mdma_words == 8'd3, "R5 reverse dir", {mdma_dir, mdma_words}, 9'd3);
        done_pulse(1);
        clr_int(4'b1111);

        // R6 key load
        wr_cmd(mk_key(3'd5));
        wait_pulse(2, seen);
        chk(seen, "R6 key pulse", 32'(seen), 1);
        chk(key_tbl_sel == 2'd3 && key_ram_sel && key_id == 6'd13, "R6 key fields",
            {key_tbl_sel, key_ram_sel, key_id}, {2'd3, 1'b1, 6'd13});
        pulse_width(2, "R6 key pulse width");
        chk(st_engine_busy == 1'b1, "R6 busy until done", 32'(st_engine_busy), 1);
        done_pulse(2);
        chk(!st_engine_busy, "R6 idle after done", 32'(st_engine_busy), 0);

        // R2 fill, overflow, ordering
        wr_cmd(mk_start(12'h001));
        wait_pulse(0, seen);
        for (int k = 0; k < 5; k++) wr_cmd(mk_start(12'h010 + 12'(k)));
        wr_cmd(mk_start(12'h099));
        chk(int_status[2] == 1'b1, "R2 overflow flag", int_status, 4'b0100);
        for (int k = 0; k < 5; k++) begin
            done_pulse(0);
            wait_pulse(0, seen);
            chk(seen && eng_blocks == 12'h010 + 12'(k), "R2 queued order", eng_blocks, 12'h010 + 12'(k));
        end
        done_pulse(0);
        wait_pulse(0, seen);
        chk(!seen && st_queue_empty, "R2 dropped word absent", 32'(seen), 0);
        clr_int(4'b1111);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = int'($urandom % 3);
            if (kind == 0) begin
                logic [11:0] n;
                n = 12'($urandom);
                wr_cmd(mk_start(n));
                wait_pulse(0, seen);
                chk(seen && eng_blocks == n, "R4 random count", eng_blocks, 32'(n));
                done_pulse(0);
            end else if (kind == 1) begin
                logic [2:0] s;
                s = 3'($urandom);
                wr_cmd(mk_key(s));
                wait_pulse(2, seen);
                chk(seen && key_id == {3'b001, s}, "R6 random key id", key_id, {3'b001, s});
                done_pulse(2);
            end else begin
                logic [5:0] op;
                op = 6'($urandom);
                while (known_op(op)) op = op + 6'd1;
                wr_cmd({op, 26'($urandom)});
                idle(3);
                chk(int_status[1] && !st_engine_busy, "R8 random bad opcode", int_status, 4'b0010);
                clr_int(4'b0010);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule